// File: doc/BRIEF.md
# Genetic Path Optimizer Engine

This block searches for a short route through a fixed list of waypoints using a small genetic algorithm in hardware. The first waypoint is the start and the last is the goal; every waypoint in between may be kept or skipped. Each candidate route is a chromosome with one gene per intermediate waypoint. A set bit means the route passes through that waypoint. A fixed-size population of such chromosomes evolves over a fixed number of generations. Each generation is scored, random parents are mated with single-point crossover, and every child receives a one-bit mutation. The children then replace the whole population.

Software loads the waypoint coordinates through a write port while the engine is idle. It then pulses `start` together with a 16-bit seed. While the run is in progress the engine holds `busy` high. When the last generation has been scored, it raises `done` for one cycle. At that point `best_path` and `best_cost` give the cheapest route seen in any generation of the run. The cost is the sum of squared segment lengths, so no square-root unit is needed, and a lower cost is better.

Top module: `gpo_engine`

## Requirements
- R1: A write on the load port (`ld_en` high, address below NUM_PTS) stores `ld_x`/`ld_y` as that waypoint's coordinates when the engine is idle. While `busy` is high, writes are ignored and the stored coordinates stay unchanged.
- R2: The cost of a chromosome is the sum, over consecutive visited waypoints, of dx²+dy². Waypoint 0 and waypoint NUM_PTS-1 are always visited. Bit i-1 of the chromosome set means intermediate waypoint i is visited. `best_cost` always equals the cost of `best_path` under this rule.
- R3: Population member 0 of the first generation is all ones (every waypoint visited). The other initial members come from the random source. Hence `best_cost` never exceeds the all-ones cost, and within a run the tracked best cost never increases.
- R4: Offspring are made in pairs from two parents drawn at random from the current population. A cut point is chosen in 1..GENES-1. Bits at and above the cut are exchanged between the parents.
- R5: After crossover, each child has exactly one randomly chosen bit inverted.
- R6: Random choices come from a 16-bit maximal-length Galois LFSR with feedback mask 0xB400, loaded from `seed` at `start`. A zero seed is replaced by 0xACE1, so seeds 0 and 0xACE1 give identical runs.
- R7: A run scores exactly 2^POP generations, where POP is the population size, and then pulses `done` for one cycle. The run length in cycles does not depend on the coordinates or the seed.
- R8: On equal costs the earlier-scored chromosome is kept. With all waypoints coincident, the result is the all-ones path with cost 0.
- R9: `busy` is high from the cycle after an accepted `start` until `done`. A `start` while busy is ignored.
- R10: After reset, `busy`, `done`, `best_path` and `best_cost` are all zero.
- R11: The same seed and coordinates always produce the same `best_path` and `best_cost`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (accepted when idle) |
| seed | input | 16 | Random source seed, sampled with start |
| ld_en | input | 1 | Coordinate write enable |
| ld_addr | input | $clog2(NUM_PTS) | Waypoint index to write |
| ld_x | input | COORD_W | Waypoint x coordinate |
| ld_y | input | COORD_W | Waypoint y coordinate |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at end of run |
| best_path | output | NUM_PTS-2 | Best chromosome found |
| best_cost | output | 2*COORD_W+1+$clog2(NUM_PTS) | Cost of best_path |

## Verification
The assertions assume the following about the inputs. POP is even, at most 16, and a power of two. There are at least four waypoints. Writes to coordinates use in-range addresses. Under these assumptions, cut points, mutation indices and parent indices always fall inside the chromosome and population. The stimulus keeps every load address below NUM_PTS and every coordinate within COORD_W bits. It also raises `start` and `ld_en` during a run only on purpose, to exercise the ignore rules. Random coordinate sets and seeds are mixed with collinear, coincident and zigzag layouts, whose best routes or cost bounds are known in closed form.

// File: rtl/gpo_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the genetic path optimizer.
// Assumes a 16-bit random source; the constants below belong to it.
package gpo_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_EVAL_GO,
        ST_EVAL_WAIT,
        ST_BREED,
        ST_SWAP
    } gpo_state_t;

    localparam logic [15:0] GPO_LFSR_TAPS = 16'hB400;
    localparam logic [15:0] GPO_SEED_ALT  = 16'hACE1;
endpackage

// File: rtl/gpo_lfsr.sv
`timescale 1ns/1ps
// 16-bit Galois LFSR used for every random choice of the search.
// Assumes load and step are never requested in the same cycle by the caller;
// load wins if they are. A zero seed is swapped for a fixed nonzero value.
module gpo_lfsr
    import gpo_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [15:0] seed,
    input  logic        step,
    output logic [15:0] state
);
    logic [15:0] lfsr_q;

    // Register update: reload from seed, or shift with feedback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q <= GPO_SEED_ALT;
        end else if (load) begin
            lfsr_q <= (seed == 16'h0000) ? GPO_SEED_ALT : seed;
        end else if (step) begin
            lfsr_q <= lfsr_q[0] ? ((lfsr_q >> 1) ^ GPO_LFSR_TAPS) : (lfsr_q >> 1);
        end
    end

    assign state = lfsr_q;

    // R6
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != 16'h0000);
endmodule

// File: rtl/gpo_coord_mem.sv
`timescale 1ns/1ps
// Waypoint coordinate store: one entry per waypoint, packed {x, y}.
// Assumes writes come only from the load port; they are dropped while busy.
// Reading is combinational so the scorer sees data in the cycle it addresses.
module gpo_coord_mem #(
    parameter int NUM_PTS = 8,
    parameter int COORD_W = 8,
    parameter int AW      = $clog2(NUM_PTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               busy,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [COORD_W-1:0] wr_x,
    input  logic [COORD_W-1:0] wr_y,
    input  logic [AW-1:0]      rd_addr,
    output logic [COORD_W-1:0] rd_x,
    output logic [COORD_W-1:0] rd_y
);
    localparam int EW = 2 * COORD_W;

    logic [NUM_PTS*EW-1:0] mem_q;

    // Coordinate writes, accepted only when the engine is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else if (wr_en && !busy && (int'(wr_addr) < NUM_PTS)) begin
            mem_q[int'(wr_addr)*EW +: EW] <= {wr_x, wr_y};
        end
    end

    // Combinational read port for the scorer.
    always_comb begin
        {rd_x, rd_y} = mem_q[int'(rd_addr)*EW +: EW];
    end

    // R1
    coord_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mem_q));
endmodule

// File: rtl/gpo_fitness.sv
`timescale 1ns/1ps
// Sequential path scorer: walks the waypoints once, accumulating the squared
// segment length from the last visited point to each visited point.
// Assumes start is only raised while it is idle; takes NUM_PTS cycles, then
// pulses valid with the final cost on cost.
module gpo_fitness #(
    parameter int NUM_PTS = 8,
    parameter int COORD_W = 8,
    parameter int FIT_W   = 20,
    parameter int GENES   = NUM_PTS - 2,
    parameter int AW      = $clog2(NUM_PTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [GENES-1:0]   chrom,
    output logic [AW-1:0]      rd_addr,
    input  logic [COORD_W-1:0] rd_x,
    input  logic [COORD_W-1:0] rd_y,
    output logic               valid,
    output logic [FIT_W-1:0]   cost
);
    logic                 run_q;
    logic [AW-1:0]        idx_q;
    logic [COORD_W-1:0]   px_q, py_q;
    logic [FIT_W-1:0]     acc_q;
    logic [NUM_PTS-1:0]   visit_q;
    logic                 valid_q;
    logic [COORD_W-1:0]   dx, dy;
    logic [FIT_W-1:0]     seg;
    logic                 is_last;
    logic                 visit;

    assign rd_addr = run_q ? idx_q : '0;

    // Segment length squared from last visited point to the current point.
    always_comb begin
        dx      = (rd_x >= px_q) ? (rd_x - px_q) : (px_q - rd_x);
        dy      = (rd_y >= py_q) ? (rd_y - py_q) : (py_q - rd_y);
        seg     = FIT_W'(dx) * FIT_W'(dx) + FIT_W'(dy) * FIT_W'(dy);
        is_last = (idx_q == AW'(NUM_PTS - 1));
        visit   = visit_q[idx_q];
    end

    // Walk control and accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            idx_q   <= '0;
            px_q    <= '0;
            py_q    <= '0;
            acc_q   <= '0;
            visit_q <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (start && !run_q) begin
                run_q   <= 1'b1;
                idx_q   <= AW'(1);
                px_q    <= rd_x;
                py_q    <= rd_y;
                acc_q   <= '0;
                visit_q <= {1'b1, chrom, 1'b1};
            end else if (run_q) begin
                if (visit) begin
                    acc_q <= acc_q + seg;
                    px_q  <= rd_x;
                    py_q  <= rd_y;
                end
                if (is_last) begin
                    run_q   <= 1'b0;
                    valid_q <= 1'b1;
                end else begin
                    idx_q <= idx_q + AW'(1);
                end
            end
        end
    end

    assign valid = valid_q;
    assign cost  = acc_q;

    // R2
    acc_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q)) |-> (acc_q >= $past(acc_q)));

    // R2
    valid_after_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> ($past(run_q) && !run_q));
endmodule

// File: rtl/gpo_breed.sv
`timescale 1ns/1ps
// Offspring generator: single-point crossover of two parents followed by a
// one-bit mutation of each child. Purely combinational; the clock only
// serves the checks. Assumes cut lies in 1..GENES-1 and mutation indices
// lie below GENES.
module gpo_breed #(
    parameter int GENES = 6,
    parameter int IW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             check_en,
    input  logic [GENES-1:0] parent_a,
    input  logic [GENES-1:0] parent_b,
    input  logic [IW-1:0]    cut,
    input  logic [IW-1:0]    mut_a,
    input  logic [IW-1:0]    mut_b,
    output logic [GENES-1:0] child_a,
    output logic [GENES-1:0] child_b
);
    logic [GENES-1:0] tail_mask;
    logic [GENES-1:0] cross_a, cross_b;
    logic [GENES-1:0] flip_a, flip_b;

    // Tail exchange above the cut, then one flipped bit per child.
    always_comb begin
        tail_mask = {GENES{1'b1}} << cut;
        cross_a   = (parent_a & ~tail_mask) | (parent_b & tail_mask);
        cross_b   = (parent_b & ~tail_mask) | (parent_a & tail_mask);
        flip_a    = GENES'(1) << mut_a;
        flip_b    = GENES'(1) << mut_b;
        child_a   = cross_a ^ flip_a;
        child_b   = cross_b ^ flip_b;
    end

    // R4
    cut_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        check_en |-> (int'(cut) >= 1 && int'(cut) <= GENES - 1));

    // R4
    swap_conserves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        check_en |-> (((child_a ^ flip_a) ^ (child_b ^ flip_b)) == (parent_a ^ parent_b)));

    // R5
    single_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        check_en |-> ($countones(flip_a) == 1 && $countones(flip_b) == 1));
endmodule

// File: rtl/gpo_engine.sv
`timescale 1ns/1ps
// Genetic path optimizer top. Holds the population, sequences scoring,
// breeding and replacement for 2^POP generations, and tracks the best route.
// Assumes POP is even, a power of two and at most 16, NUM_PTS >= 4 and
// NUM_PTS - 2 <= 16.
module gpo_engine
    import gpo_pkg::*;
#(
    parameter int NUM_PTS = 8,
    parameter int COORD_W = 8,
    parameter int POP     = 4
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    start,
    input  logic [15:0]                             seed,
    input  logic                                    ld_en,
    input  logic [$clog2(NUM_PTS)-1:0]              ld_addr,
    input  logic [COORD_W-1:0]                      ld_x,
    input  logic [COORD_W-1:0]                      ld_y,
    output logic                                    busy,
    output logic                                    done,
    output logic [NUM_PTS-3:0]                      best_path,
    output logic [2*COORD_W+$clog2(NUM_PTS):0]      best_cost
);
    localparam int AW    = $clog2(NUM_PTS);
    localparam int GENES = NUM_PTS - 2;
    localparam int IW    = (GENES > 1) ? $clog2(GENES) : 1;
    localparam int PW    = (POP > 1) ? $clog2(POP) : 1;
    localparam int GENS  = 1 << POP;
    localparam int GW    = POP;
    localparam int FIT_W = 2 * COORD_W + 1 + AW;

    gpo_state_t        state_q;
    logic [PW-1:0]     idx_q;
    logic [PW-1:0]     pair_q;
    logic [GW-1:0]     gen_q;
    logic [GENES-1:0]  pop_q  [POP];
    logic [GENES-1:0]  next_q [POP];
    logic [GENES-1:0]  best_path_q;
    logic [FIT_W-1:0]  best_cost_q;
    logic              have_best_q;
    logic              done_q;

    logic [15:0]       lfsr_state;
    logic [31:0]       rv;
    logic [PW-1:0]     sel_a, sel_b;
    logic [IW-1:0]     cut, mut_a, mut_b;
    logic [GENES-1:0]  child_a, child_b;
    logic [AW-1:0]     rd_addr;
    logic [COORD_W-1:0] rd_x, rd_y;
    logic              fit_valid;
    logic [FIT_W-1:0]  fit_cost;
    logic              fit_start;
    logic              busy_w;

    assign busy_w    = (state_q != ST_IDLE);
    assign fit_start = (state_q == ST_EVAL_GO);

    gpo_lfsr u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (!busy_w && start),
        .seed  (seed),
        .step  (busy_w),
        .state (lfsr_state)
    );

    gpo_coord_mem #(.NUM_PTS(NUM_PTS), .COORD_W(COORD_W), .AW(AW)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy_w),
        .wr_en   (ld_en),
        .wr_addr (ld_addr),
        .wr_x    (ld_x),
        .wr_y    (ld_y),
        .rd_addr (rd_addr),
        .rd_x    (rd_x),
        .rd_y    (rd_y)
    );

    gpo_fitness #(.NUM_PTS(NUM_PTS), .COORD_W(COORD_W), .FIT_W(FIT_W),
                  .GENES(GENES), .AW(AW)) u_fit (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (fit_start),
        .chrom   (pop_q[idx_q]),
        .rd_addr (rd_addr),
        .rd_x    (rd_x),
        .rd_y    (rd_y),
        .valid   (fit_valid),
        .cost    (fit_cost)
    );

    // Random word split into parent picks, cut point and mutation indices.
    always_comb begin
        rv    = {lfsr_state, lfsr_state ^ {lfsr_state[7:0], lfsr_state[15:8]}};
        sel_a = PW'(int'(rv[PW-1:0]) % POP);
        sel_b = PW'(int'(rv[2*PW-1:PW]) % POP);
        cut   = IW'((int'(rv[2*PW+7:2*PW]) % (GENES - 1)) + 1);
        mut_a = IW'(int'(rv[2*PW+15:2*PW+8]) % GENES);
        mut_b = IW'(int'(rv[2*PW+23:2*PW+16]) % GENES);
    end

    gpo_breed #(.GENES(GENES), .IW(IW)) u_breed (
        .clk      (clk),
        .rst_n    (rst_n),
        .check_en (state_q == ST_BREED),
        .parent_a (pop_q[sel_a]),
        .parent_b (pop_q[sel_b]),
        .cut      (cut),
        .mut_a    (mut_a),
        .mut_b    (mut_b),
        .child_a  (child_a),
        .child_b  (child_b)
    );

    // Run sequencer: seed, score each member, breed, replace, repeat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            idx_q       <= '0;
            pair_q      <= '0;
            gen_q       <= '0;
            best_path_q <= '0;
            best_cost_q <= '0;
            have_best_q <= 1'b0;
            done_q      <= 1'b0;
            for (int k = 0; k < POP; k++) begin
                pop_q[k]  <= '0;
                next_q[k] <= '0;
            end
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q     <= ST_INIT;
                        idx_q       <= '0;
                        have_best_q <= 1'b0;
                    end
                end
                ST_INIT: begin
                    pop_q[idx_q] <= (idx_q == '0) ? {GENES{1'b1}} : lfsr_state[GENES-1:0];
                    if (idx_q == PW'(POP - 1)) begin
                        idx_q   <= '0;
                        gen_q   <= '0;
                        state_q <= ST_EVAL_GO;
                    end else begin
                        idx_q <= idx_q + PW'(1);
                    end
                end
                ST_EVAL_GO: begin
                    state_q <= ST_EVAL_WAIT;
                end
                ST_EVAL_WAIT: begin
                    if (fit_valid) begin
                        if (!have_best_q || (fit_cost < best_cost_q)) begin
                            best_cost_q <= fit_cost;
                            best_path_q <= pop_q[idx_q];
                            have_best_q <= 1'b1;
                        end
                        if (idx_q == PW'(POP - 1)) begin
                            idx_q <= '0;
                            if (gen_q == GW'(GENS - 1)) begin
                                state_q <= ST_IDLE;
                                done_q  <= 1'b1;
                            end else begin
                                pair_q  <= '0;
                                state_q <= ST_BREED;
                            end
                        end else begin
                            idx_q   <= idx_q + PW'(1);
                            state_q <= ST_EVAL_GO;
                        end
                    end
                end
                ST_BREED: begin
                    next_q[PW'(2 * int'(pair_q))]     <= child_a;
                    next_q[PW'(2 * int'(pair_q) + 1)] <= child_b;
                    if (pair_q == PW'(POP / 2 - 1)) begin
                        state_q <= ST_SWAP;
                    end else begin
                        pair_q <= pair_q + PW'(1);
                    end
                end
                ST_SWAP: begin
                    for (int k = 0; k < POP; k++) begin
                        pop_q[k] <= next_q[k];
                    end
                    gen_q   <= gen_q + GW'(1);
                    idx_q   <= '0;
                    state_q <= ST_EVAL_GO;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = busy_w;
    assign done      = done_q;
    assign best_path = best_path_q;
    assign best_cost = best_cost_q;

    // R3
    best_never_worse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (have_best_q && $past(have_best_q)) |-> (best_cost_q <= $past(best_cost_q)));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R7
    done_last_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (gen_q == GW'(GENS - 1) && !busy_w));

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_w && start) |=> !(state_q == ST_INIT && idx_q == '0));
endmodule

// File: tb/tb_gpo_engine.sv
`timescale 1ns/1ps
module tb_gpo_engine;
    localparam int NP = 8;
    localparam int CW = 8;
    localparam int GN = NP - 2;
    localparam int AW = $clog2(NP);
    localparam int FW = 2 * CW + 1 + AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [15:0]   seed = '0;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [CW-1:0] ld_x = '0;
    logic [CW-1:0] ld_y = '0;
    logic          busy, done;
    logic [GN-1:0] best_path;
    logic [FW-1:0] best_cost;

    int checks = 0;
    int fails  = 0;
    int bx [NP];
    int by [NP];
    int ref_lat = -1;

    gpo_engine #(.NUM_PTS(NP), .COORD_W(CW), .POP(4)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .seed(seed),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_x(ld_x), .ld_y(ld_y),
        .busy(busy), .done(done), .best_path(best_path), .best_cost(best_cost)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int cost_of(input logic [GN-1:0] p);
        int acc = 0;
        int prev = 0;
        for (int i = 1; i < NP; i++) begin
            if (i == NP - 1 || p[i-1]) begin
                acc += (bx[i] - bx[prev]) * (bx[i] - bx[prev])
                     + (by[i] - by[prev]) * (by[i] - by[prev]);
                prev = i;
            end
        end
        return acc;
    endfunction

    task automatic put_point(input int i, input int x, input int y);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = AW'(i); ld_x = CW'(x); ld_y = CW'(y);
        bx[i] = x; by[i] = y;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic do_run(input logic [15:0] s, input bit disturb,
                          output logic [GN-1:0] p, output int c);
        int lat;
        @(negedge clk);
        seed = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 20000) begin
            if (disturb && lat == 50) begin
                start = 1'b1; ld_en = 1'b1; ld_addr = AW'(3);
                ld_x = 8'hFF; ld_y = 8'hFF;
            end else if (disturb && lat == 51) begin
                start = 1'b0; ld_en = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        check(done == 1'b1, "R7 done arrives", done, 1);
        p = best_path;
        c = int'(best_cost);
        if (ref_lat < 0) ref_lat = lat;
        // R7: run length independent of data and seed
        check(lat == ref_lat, "R7 latency", lat, ref_lat);
        @(negedge clk);
        // R7: done lasts one cycle; R9: busy low afterwards
        check(done == 1'b0, "R7 done width", done, 0);
        check(busy == 1'b0, "R9 idle after done", busy, 0);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [GN-1:0] p0, p1, p2;
        int c0, c1, c2;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(busy == 1'b0, "R10 busy", busy, 0);
        check(done == 1'b0, "R10 done", done, 0);
        check(best_cost == '0, "R10 best_cost", best_cost, 0);
        check(best_path == '0, "R10 best_path", best_path, 0);

        // Collinear, evenly spaced: visiting every point is the unique optimum
        for (int i = 0; i < NP; i++) put_point(i, 10 * i, 5 * i);
        do_run(16'h1234, 1'b0, p0, c0);
        check(c0 == 875, "R2 collinear cost", c0, 875);
        check(p0 == {GN{1'b1}}, "R3 collinear path", p0, {GN{1'b1}});

        // R8: coincident points, tie keeps the first scored (all ones)
        for (int i = 0; i < NP; i++) put_point(i, 77, 77);
        do_run(16'h00F0, 1'b0, p0, c0);
        check(c0 == 0, "R8 tie cost", c0, 0);
        check(p0 == {GN{1'b1}}, "R8 tie path", p0, {GN{1'b1}});

        // R4 R5: zigzag, the all-ones route is the worst; search must beat it
        for (int i = 0; i < NP; i++) put_point(i, 30 * i, (i % 2) * 200);
        do_run(16'hBEEF, 1'b0, p0, c0);
        check(c0 < cost_of({GN{1'b1}}), "R4 improves on member 0", c0, cost_of({GN{1'b1}}));
        check(c0 == cost_of(p0), "R5 cost matches path", c0, cost_of(p0));

        // Random coordinate sets and seeds
        for (int t = 0; t < 6; t++) begin
            logic [15:0] s;
            for (int i = 0; i < NP; i++) put_point(i, $urandom_range(0, 255), $urandom_range(0, 255));
            s = 16'($urandom_range(1, 65535));
            do_run(s, 1'b0, p0, c0);
            check(c0 == cost_of(p0), "R2 cost of best_path", c0, cost_of(p0));
            check(c0 <= cost_of({GN{1'b1}}), "R3 bounded by all-ones", c0, cost_of({GN{1'b1}}));
            do_run(s, 1'b0, p1, c1);
            check(p1 == p0 && c1 == c0, "R11 repeatable", c1, c0);
        end

        // R6: zero seed behaves as 0xACE1
        do_run(16'h0000, 1'b0, p0, c0);
        do_run(16'hACE1, 1'b0, p1, c1);
        check(p0 == p1, "R6 zero seed path", p0, p1);
        check(c0 == c1, "R6 zero seed cost", c0, c1);

        // R1 R9: start and coordinate writes during a run are ignored
        do_run(16'h5A5A, 1'b0, p0, c0);
        do_run(16'h5A5A, 1'b1, p1, c1);
        check(p1 == p0 && c1 == c0, "R9 disturbed run unchanged", c1, c0);
        do_run(16'h5A5A, 1'b0, p2, c2);
        check(p2 == p0 && c2 == c0, "R1 coords untouched by busy write", c2, c0);
        check(c2 == cost_of(p2), "R1 cost uses stored coords", c2, cost_of(p2));

        // R1: an idle write does take effect
        put_point(3, 255, 255);
        do_run(16'h5A5A, 1'b0, p2, c2);
        check(c2 == cost_of(p2), "R1 idle write applied", c2, cost_of(p2));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule